// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in a receive path and decides, frame by frame, whether an incoming Ethernet frame is kept. It captures the first six bytes of the frame (the destination address) from a byte stream. It classifies the address as broadcast, multicast or unicast. It matches the address against a programmed station address. For multicast, it also looks up one bit of a 64-entry hash table. The table index is derived from the CRC-32 of the address. A 2-bit filter mode then turns these results into a single accept decision. Every classification flag is also exposed, so the receive status word can record them.

The byte stream uses a valid/ready handshake. A byte is transferred on a rising clock edge when `dst_valid` and `dst_ready` are both high. `dst_sof` is sampled only on such a transfer, and it marks that byte as the first byte of a new frame. The filter never applies back-pressure: `dst_ready` is high whenever reset is released. Bytes after the sixth one are taken and ignored, so the payload can flow through the same port. The mode, the station address and the hash table are plain control inputs and are read live. The hash status bit keeps the most recent table lookup while the receive path is enabled.

Top module: `dst_addr_filter`

## Requirements
- R1: During and after reset, `decision_valid`, `accept`, all classification flags and `hash_status` are 0.
- R2: Destination bytes arrive most significant first: the first byte on the stream is `station_addr[47:40]`, and the sixth byte is `station_addr[7:0]`. A byte counts only when `dst_valid` and `dst_ready` are both high. `decision_valid` rises in the cycle after the sixth byte is transferred, and never earlier.
- R3: `phys_match` is 1 exactly when all 48 captured address bits equal `station_addr`.
- R4: `is_multicast` is bit 0 of the first destination byte. `is_broadcast` is 1 when all 48 bits are 1, and a broadcast frame also has `is_multicast` set.
- R5: The hash index is the low 6 bits of a CRC register. The register starts at all ones and processes the six bytes in stream order, each byte least significant bit first. It uses the reflected polynomial 0xEDB88320, and there is no final inversion. `hash_match` is `is_multicast` AND `hash_table[index]`.
- R6: Mode 2'b00 accepts only frames with `phys_match`.
- R7: Mode 2'b01 accepts frames with `phys_match`, `is_broadcast` or `hash_match`.
- R8: Mode 2'b10 accepts frames with `phys_match`, `is_broadcast` or `is_multicast`, whatever the hash lookup gives.
- R9: Mode 2'b11 accepts every frame.
- R10: After the decision is valid, the flags and `decision_valid` hold until the next transfer that has `dst_sof` set. Payload bytes do not change them. Bytes transferred before any start of frame are ignored.
- R11: In every cycle where `rx_enable` and `decision_valid` are both high, `hash_status` takes the selected hash table bit. Otherwise it holds its value.
- R12: `dst_ready` is 1 whenever `rst_n` is high.
- R13: While `decision_valid` is 0, `accept` and all classification flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_mode | input | 2 | Acceptance policy (R6 to R9) |
| rx_enable | input | 1 | Receive path enabled; allows `hash_status` to update |
| station_addr | input | 48 | Programmed own address, first byte in [47:40] |
| hash_table | input | 64 | Multicast hash filter bits |
| dst_valid | input | 1 | Stream byte valid |
| dst_ready | output | 1 | Stream ready; never deasserted outside reset |
| dst_sof | input | 1 | First byte of a frame, qualified by the transfer |
| dst_data | input | 8 | Stream byte |
| decision_valid | output | 1 | Decision and flags are valid for the current frame |
| accept | output | 1 | Frame is kept |
| phys_match | output | 1 | Destination equals the station address |
| hash_match | output | 1 | Multicast frame whose hash bit is set |
| is_broadcast | output | 1 | Destination is all ones |
| is_multicast | output | 1 | Group bit of the destination is set |
| hash_status | output | 1 | Latched hash lookup result |

## Verification
The bench checks `decision_valid` one cycle before and one cycle after the sixth byte, with and without gaps in `dst_valid`. An off-by-one byte counter would flag the frame early or late, or would capture bytes into the wrong slots. The bench builds multicast frames whose table bit is set and frames whose bit is clear, and it steps through all four modes. A wrong CRC bit order, or a mode that ignores the hash, would then flip `accept`. The broadcast address is checked in the own-address-only mode, where it must be rejected even though it is a group address. Payload bytes, and bytes sent before any start of frame, must leave the flags untouched. The bench also toggles `rx_enable` to check that `hash_status` freezes while the receive path is disabled.

// File: rtl/dst_filter_pkg.sv
package dst_filter_pkg;

  typedef enum logic [1:0] {
    FM_OWN_ONLY = 2'b00,
    FM_HASHED   = 2'b01,
    FM_ALL_MC   = 2'b10,
    FM_PROMISC  = 2'b11
  } filt_mode_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  // One byte of the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  b);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

endpackage

// File: rtl/dst_addr_capture.sv
module dst_addr_capture #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    sof,
  input  logic [7:0]              byte_in,
  output logic                    take,
  output logic                    first,
  output logic [8*ADDR_BYTES-1:0] addr,
  output logic                    done
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ADDR_BYTES);

  logic [CNT_W-1:0] cnt;

  assign first = beat && sof;
  assign take  = first || (beat && (cnt != '0) && (cnt < FULL));
  assign done  = (cnt == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      addr <= '0;
    end else if (first) begin
      cnt <= CNT_W'(1);
      addr[8*(ADDR_BYTES-1) +: 8] <= byte_in;
    end else if (take) begin
      cnt <= cnt + CNT_W'(1);
      addr[8*(ADDR_BYTES-1-int'(cnt)) +: 8] <= byte_in;
    end
  end
endmodule

// File: rtl/dst_crc_hash.sv
module dst_crc_hash
  import dst_filter_pkg::*;
#(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 first,
  input  logic [7:0]           byte_in,
  output logic [HASH_BITS-1:0] index
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= '1;
    else if (first) crc_q <= crc_step_byte(32'hFFFF_FFFF, byte_in);
    else if (take)  crc_q <= crc_step_byte(crc_q, byte_in);
  end

  assign index = crc_q[HASH_BITS-1:0];
endmodule

// File: rtl/dst_accept_policy.sv
module dst_accept_policy
  import dst_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic [1:0]              mode,
  input  logic [8*ADDR_BYTES-1:0] addr,
  input  logic [8*ADDR_BYTES-1:0] station,
  input  logic [(1<<HASH_BITS)-1:0] table_bits,
  input  logic [HASH_BITS-1:0]    index,
  input  logic                    done,
  output logic                    accept,
  output logic                    phys,
  output logic                    hashm,
  output logic                    bcast,
  output logic                    mcast,
  output logic                    sel_bit
);
  localparam int GROUP_BIT = 8*(ADDR_BYTES-1);

  logic raw_phys, raw_mc, raw_bc, raw_hash, raw_acc;

  always_comb begin
    sel_bit  = table_bits[index];
    raw_phys = (addr == station);
    raw_mc   = addr[GROUP_BIT];
    raw_bc   = &addr;
    raw_hash = raw_mc && sel_bit;
    unique case (filt_mode_e'(mode))
      FM_OWN_ONLY: raw_acc = raw_phys;
      FM_HASHED:   raw_acc = raw_phys || raw_bc || raw_hash;
      FM_ALL_MC:   raw_acc = raw_phys || raw_bc || raw_mc;
      FM_PROMISC:  raw_acc = 1'b1;
      default:     raw_acc = 1'b0;
    endcase
    accept = done && raw_acc;
    phys   = done && raw_phys;
    hashm  = done && raw_hash;
    bcast  = done && raw_bc;
    mcast  = done && raw_mc;
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                filt_mode,
  input  logic                      rx_enable,
  input  logic [8*ADDR_BYTES-1:0]   station_addr,
  input  logic [(1<<HASH_BITS)-1:0] hash_table,
  input  logic                      dst_valid,
  output logic                      dst_ready,
  input  logic                      dst_sof,
  input  logic [7:0]                dst_data,
  output logic                      decision_valid,
  output logic                      accept,
  output logic                      phys_match,
  output logic                      hash_match,
  output logic                      is_broadcast,
  output logic                      is_multicast,
  output logic                      hash_status
);
  logic                    beat, take, first, done, sel_bit;
  logic [8*ADDR_BYTES-1:0] addr;
  logic [HASH_BITS-1:0]    index;

  assign dst_ready      = rst_n;
  assign beat           = dst_valid && dst_ready;
  assign decision_valid = done;

  dst_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(dst_sof), .byte_in(dst_data),
    .take(take), .first(first), .addr(addr), .done(done)
  );

  dst_crc_hash #(.HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .take(take), .first(first), .byte_in(dst_data),
    .index(index)
  );

  dst_accept_policy #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS)) u_pol (
    .mode(filt_mode), .addr(addr), .station(station_addr), .table_bits(hash_table),
    .index(index), .done(done), .accept(accept), .phys(phys_match),
    .hashm(hash_match), .bcast(is_broadcast), .mcast(is_multicast), .sel_bit(sel_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 hash_status <= 1'b0;
    else if (rx_enable && done) hash_status <= sel_bit;
  end
endmodule

// File: rtl/dst_addr_filter_chk.sv
module dst_addr_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] filt_mode,
  input logic       rx_enable,
  input logic       dst_valid,
  input logic       dst_ready,
  input logic       dst_sof,
  input logic       decision_valid,
  input logic       accept,
  input logic       phys_match,
  input logic       hash_match,
  input logic       is_broadcast,
  input logic       is_multicast,
  input logic       hash_status
);
  // R13
  flags_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !decision_valid |-> !(accept || phys_match || hash_match || is_broadcast || is_multicast));

  // R4
  bcast_is_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_broadcast |-> is_multicast);

  // R5
  hash_needs_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hash_match |-> is_multicast);

  // R6
  own_addr_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && phys_match) |-> accept);

  // R8
  all_group_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && filt_mode == 2'b10 && is_multicast) |-> accept);

  // R9
  promisc_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && filt_mode == 2'b11) |-> accept);

  // R2
  valid_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decision_valid) |-> $past(dst_valid && dst_ready));

  // R10
  hold_until_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (decision_valid && !(dst_valid && dst_ready && dst_sof)) |=>
      (decision_valid && $stable(is_multicast) && $stable(is_broadcast)));

  // R11
  status_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> $stable(hash_status));

  // R12
  ready_out_of_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_ready);
endmodule

bind dst_addr_filter dst_addr_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .filt_mode(filt_mode), .rx_enable(rx_enable),
  .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_sof(dst_sof),
  .decision_valid(decision_valid), .accept(accept), .phys_match(phys_match),
  .hash_match(hash_match), .is_broadcast(is_broadcast), .is_multicast(is_multicast),
  .hash_status(hash_status)
);

// File: tb/dst_addr_filter_test.sv
module dst_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  filt_mode = 2'b00;
  logic        rx_enable = 1'b0;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic [63:0] hash_table = '0;
  logic        dst_valid = 1'b0;
  logic        dst_sof = 1'b0;
  logic [7:0]  dst_data = '0;
  logic        dst_ready, decision_valid, accept, phys_match, hash_match;
  logic        is_broadcast, is_multicast, hash_status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dst_addr_filter uut (
    .clk(clk), .rst_n(rst_n), .filt_mode(filt_mode), .rx_enable(rx_enable),
    .station_addr(station_addr), .hash_table(hash_table),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_sof(dst_sof), .dst_data(dst_data),
    .decision_valid(decision_valid), .accept(accept), .phys_match(phys_match),
    .hash_match(hash_match), .is_broadcast(is_broadcast), .is_multicast(is_multicast),
    .hash_status(hash_status)
  );

  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      logic [7:0] b = a[47-8*k -: 8];
      for (int j = 0; j < 8; j++) begin
        logic fb = c[0] ^ b[j];
        c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB8_8320 : 32'h0);
      end
    end
    return c[5:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic s);
    dst_valid = 1'b1; dst_data = b; dst_sof = s;
    @(negedge clk);
    dst_valid = 1'b0; dst_sof = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_addr(input logic [47:0] a, input bit gaps);
    for (int i = 0; i < 6; i++) begin
      put(a[47-8*i -: 8], i == 0);
      if (gaps) idle(2);
      if (i == 4) check("R2 not valid after five bytes", decision_valid, 0);
    end
  endtask

  task automatic t_reset;
    check("R1 valid", decision_valid, 0);
    check("R1 hash_status", hash_status, 0);
    check("R13 flags", {accept, phys_match, hash_match, is_broadcast, is_multicast}, 0);
    check("R12 ready", dst_ready, 1);
    for (int i = 0; i < 8; i++) put(8'hFF, 1'b0);
    check("R10 bytes before sof ignored", decision_valid, 0);
  endtask

  task automatic t_physical;
    filt_mode = 2'b00;
    send_addr(station_addr, 1'b0);
    check("R2 valid after sixth byte", decision_valid, 1);
    check("R3 own address matches", phys_match, 1);
    check("R6 own address kept", accept, 1);
    check("R4 unicast not group", is_multicast, 0);
    send_addr(48'h02_11_22_33_44_54, 1'b0);
    check("R3 near miss", phys_match, 0);
    check("R6 other unicast dropped", accept, 0);
  endtask

  task automatic t_broadcast;
    filt_mode = 2'b00;
    send_addr(48'hFFFF_FFFF_FFFF, 1'b0);
    check("R4 broadcast flag", is_broadcast, 1);
    check("R4 broadcast is group", is_multicast, 1);
    check("R6 broadcast dropped in own mode", accept, 0);
    filt_mode = 2'b01; #1;
    check("R7 broadcast kept", accept, 1);
  endtask

  task automatic t_hash_modes;
    logic [47:0] m = 48'h01_00_5E_12_34_56;
    logic [5:0]  ix = ref_index(m);
    hash_table = 64'd1 << ix;
    filt_mode = 2'b00;
    send_addr(m, 1'b1);
    check("R4 group frame", {is_multicast, is_broadcast}, 2'b10);
    check("R6 group dropped in own mode", accept, 0);
    filt_mode = 2'b01; #1;
    check("R5 hash hit", hash_match, 1);
    check("R7 hash hit kept", accept, 1);
    hash_table = 64'd1 << (ix ^ 6'd1); #1;
    check("R5 neighbour bit misses", hash_match, 0);
    check("R7 hash miss dropped", accept, 0);
    filt_mode = 2'b10; #1;
    check("R8 all group kept", accept, 1);
    filt_mode = 2'b11;
    send_addr(48'h04_AA_BB_CC_DD_EE, 1'b0);
    check("R9 promiscuous keeps unicast", accept, 1);
    filt_mode = 2'b01; #1;
    check("R7 foreign unicast dropped", accept, 0);
  endtask

  task automatic t_hold;
    filt_mode = 2'b10;
    send_addr(48'h01_00_00_00_00_07, 1'b1);
    for (int i = 0; i < 10; i++) put(8'hFF, 1'b0);
    check("R10 payload leaves valid", decision_valid, 1);
    check("R10 payload leaves flags", {is_multicast, is_broadcast, accept}, 3'b101);
    put(8'h02, 1'b1);
    check("R10 sof ends decision", decision_valid, 0);
    check("R13 flags cleared", {accept, is_multicast}, 0);
  endtask

  task automatic t_hash_status;
    logic [47:0] m = 48'h33_33_00_00_00_01;
    logic [5:0]  ix = ref_index(m);
    hash_table = 64'd1 << ix;
    rx_enable = 1'b0;
    send_addr(m, 1'b0);
    idle(2);
    check("R11 frozen while disabled", hash_status, 0);
    rx_enable = 1'b1;
    idle(2);
    check("R11 latches hit", hash_status, 1);
    rx_enable = 1'b0;
    hash_table = '0;
    send_addr(m, 1'b0);
    idle(2);
    check("R11 holds when disabled", hash_status, 1);
    rx_enable = 1'b1;
    idle(2);
    check("R11 latches miss", hash_status, 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    t_reset_pre();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_physical;
    t_broadcast;
    t_hash_modes;
    t_hold;
    t_hash_status;
    finish_run;
  end

  task automatic t_reset_pre;
    check("R1 valid in reset", decision_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run;
  end
endmodule